// File: doc/BRIEF.md
# Latched Protection and Fault-Code Manager

This block sits between the analog protection comparators of a synchronous buck controller and its gate-drive and power-good logic. It receives one digital flag per comparator: overcurrent, short circuit, overvoltage above the trip level, overvoltage above the release level, undervoltage, over-temperature above the trip level and over-temperature above the cool-down level. It also receives a strobe that marks each PWM pulse's current sample and a one-microsecond tick. It applies the timing rules for each fault class and latches the converter off when a class qualifies. It runs the low-side crowbar while an overvoltage fault is latched, and it presents a two-bit code that selects which pull-down strength the power-good pad applies.

The overcurrent and short-circuit qualifiers measure elapsed time in ticks, not pulse counts. Over-temperature only pauses switching and never latches. A latched fault stays until the enable input falls or the supply-ready input is lost. Either of those events also clears every qualifier and the thermal hold.

Top module: `prot_fault_mgr`

## Requirements
- R1: Once a strobe samples the overcurrent flag high, a timer counts ticks for as long as every later strobe also samples it high. On the (OC_TIME_US+1)-th tick after the arming strobe, the block latches a current fault. The number of strobes in that window has no effect.
- R2: A strobe that samples the overcurrent flag low resets the timer to zero. A later high sample must then see a full OC_TIME_US+1 ticks before the fault latches.
- R3: A short-circuit fault latches when two successive strobes both sample the short-circuit flag high and fewer than SC_TIME_US ticks separate them. When SC_TIME_US or more ticks separate them, no fault latches and the second strobe starts a new window.
- R4: A high overvoltage trip flag latches an overvoltage fault and turns the crowbar output on. The crowbar turns off when the release flag is low, which means feedback is below the release level. It turns on again each time the trip flag rises, for as long as the overvoltage fault stays latched. The crowbar is never on under any other latched code.
- R5: A high undervoltage flag latches an undervoltage fault, and the fault stays latched after the flag falls.
- R6: A high over-temperature trip flag takes the switch enable low on the next cycle. The enable stays low until the cool-down flag is low, and then switching resumes without any latch. Power-good is not affected.
- R7: The pg_code output takes these values: 00 means open, 01 means weak pull-down, 10 means medium pull-down and 11 means strong pull-down. A current or short-circuit fault gives 11, an overvoltage fault gives 10 and an undervoltage fault gives 01. The first fault to latch keeps its code. When faults qualify in the same cycle, current faults win over overvoltage, and overvoltage wins over undervoltage.
- R8: When enable is low or supply-ready is low, the block clears all latches, qualifiers and the thermal hold. In that same cycle pg_code is 00, the switch enable is low and the crowbar is off.
- R9: While the block is enabled and no fault is latched, pg_code is 01 when the soft-start input is high and 00 when it is low.
- R10: While any fault is latched, the switch enable is low in every cycle, and the soft-start input does not change pg_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable |
| supply_ok_i | input | 1 | Bias supply above its power-on level |
| ss_busy_i | input | 1 | Soft-start ramp in progress |
| pulse_stb_i | input | 1 | One-cycle strobe when a PWM pulse's current sample is valid |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| oc_flag_i | input | 1 | Sampled current above the overcurrent level |
| sc_flag_i | input | 1 | Sampled current above the short-circuit level |
| ov_hi_i | input | 1 | Feedback above the overvoltage trip level |
| ov_lo_i | input | 1 | Feedback above the overvoltage release level |
| uv_flag_i | input | 1 | Feedback below the undervoltage level |
| ot_hi_i | input | 1 | Die temperature above the trip level |
| ot_warm_i | input | 1 | Die temperature not yet below the cool-down level |
| pg_code_o | output | 2 | Power-good pull-down selection code |
| sw_en_o | output | 1 | High-side and normal low-side switching permitted |
| crowbar_o | output | 1 | Force the low-side switch on |

## Verification
The bound checker checks a set of rules in every cycle. The disabled state must be quiet. Switching must stop whenever a fault code is latched. The crowbar may only be on under the overvoltage code. A latched current or overvoltage code must hold while the block stays enabled. An over-temperature trip must block switching on the next cycle. The bench scenarios cover the rest. They show that the overcurrent timer qualifies only on its exact tick and restarts after a low sample. They show both sides of the short-circuit window, the release and re-trip of the crowbar, the priority between faults that qualify together, and thermal recovery.

// File: rtl/prot_pkg.sv
package prot_pkg;
  // Power-good pull-down selection; code value is the pad's strength index.
  typedef enum logic [1:0] {
    PG_OPEN   = 2'b00,
    PG_WEAK   = 2'b01,
    PG_MED    = 2'b10,
    PG_STRONG = 2'b11
  } pg_code_e;
endpackage

// File: rtl/prot_oc_qual.sv
// Duration qualifier: trips after more than LIMIT ticks of unbroken over-level samples.
module prot_oc_qual #(
  parameter int unsigned LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic stb_i,
  input  logic tick_i,
  input  logic flag_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);

  logic          armed_q, armed_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          upd;

  assign upd = clr_i | stb_i | tick_i;

  always_comb begin
    armed_n = armed_q;
    cnt_n   = cnt_q;
    if (clr_i) begin
      armed_n = 1'b0;
      cnt_n   = '0;
    end else begin
      if (tick_i && armed_q && (cnt_q != CMAX)) cnt_n = cnt_q + 1'b1;
      if (stb_i) begin
        if (!flag_i) begin
          armed_n = 1'b0;
          cnt_n   = '0;
        end else if (!armed_q) begin
          armed_n = 1'b1;
          cnt_n   = '0;
        end
      end
    end
  end

  assign trip_o = !clr_i && armed_q && tick_i && (cnt_q == CMAX) && !(stb_i && !flag_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (upd) begin
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
    end
  end
endmodule

// File: rtl/prot_sc_qual.sv
// Window qualifier: trips when two successive flagged strobes are under LIMIT ticks apart.
module prot_sc_qual #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic stb_i,
  input  logic tick_i,
  input  logic flag_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);

  logic          armed_q, armed_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          upd;

  assign upd = clr_i | stb_i | tick_i;

  always_comb begin
    armed_n = armed_q;
    cnt_n   = cnt_q;
    if (clr_i) begin
      armed_n = 1'b0;
      cnt_n   = '0;
    end else begin
      if (tick_i && armed_q && (cnt_q != CMAX)) cnt_n = cnt_q + 1'b1;
      if (stb_i) begin
        armed_n = flag_i;
        cnt_n   = '0;
      end
    end
  end

  assign trip_o = !clr_i && stb_i && flag_i && armed_q && (cnt_q < CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (upd) begin
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
    end
  end
endmodule

// File: rtl/prot_hyst_latch.sv
// Set/release hold with clear; priority clear > set > release.
module prot_hyst_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic set_i,
  input  logic rel_i,
  output logic q_o
);
  logic q_q, q_n;

  always_comb begin
    q_n = q_q;
    if (clr_i)      q_n = 1'b0;
    else if (set_i) q_n = 1'b1;
    else if (rel_i) q_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_n;
  end

  assign q_o = q_q;
endmodule

// File: rtl/prot_fault_mgr.sv
module prot_fault_mgr
  import prot_pkg::*;
#(
  parameter int unsigned OC_TIME_US = 20,
  parameter int unsigned SC_TIME_US = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       supply_ok_i,
  input  logic       ss_busy_i,
  input  logic       pulse_stb_i,
  input  logic       us_tick_i,
  input  logic       oc_flag_i,
  input  logic       sc_flag_i,
  input  logic       ov_hi_i,
  input  logic       ov_lo_i,
  input  logic       uv_flag_i,
  input  logic       ot_hi_i,
  input  logic       ot_warm_i,
  output logic [1:0] pg_code_o,
  output logic       sw_en_o,
  output logic       crowbar_o
);
  logic     active, clr;
  logic     oc_trip, sc_trip, cur_trip;
  logic     ot_hold, cb_q;
  logic     latched;
  pg_code_e code_q, code_n;

  assign active   = en_i & supply_ok_i;
  assign clr      = ~active;
  assign cur_trip = oc_trip | sc_trip;
  assign latched  = (code_q != PG_OPEN);

  prot_oc_qual #(.LIMIT(OC_TIME_US)) u_oc (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .stb_i(pulse_stb_i),
    .tick_i(us_tick_i), .flag_i(oc_flag_i), .trip_o(oc_trip)
  );

  prot_sc_qual #(.LIMIT(SC_TIME_US)) u_sc (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .stb_i(pulse_stb_i),
    .tick_i(us_tick_i), .flag_i(sc_flag_i), .trip_o(sc_trip)
  );

  // Fault latch: the first class to qualify owns the code until cleared.
  always_comb begin
    code_n = code_q;
    if (!active)        code_n = PG_OPEN;
    else if (!latched) begin
      if (cur_trip)       code_n = PG_STRONG;
      else if (ov_hi_i)   code_n = PG_MED;
      else if (uv_flag_i) code_n = PG_WEAK;
      else                code_n = PG_OPEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= PG_OPEN;
    else        code_q <= code_n;
  end

  // Thermal hold: non-latching, released on cool-down.
  prot_hyst_latch u_ot (
    .clk(clk), .rst_n(rst_n), .clr_i(clr),
    .set_i(ot_hi_i), .rel_i(~ot_warm_i), .q_o(ot_hold)
  );

  // Crowbar: hysteretic low-side hold, only under an overvoltage latch.
  prot_hyst_latch u_cb (
    .clk(clk), .rst_n(rst_n), .clr_i(clr | (code_n != PG_MED)),
    .set_i(ov_hi_i), .rel_i(~ov_lo_i), .q_o(cb_q)
  );

  assign sw_en_o   = active & ~latched & ~ot_hold;
  assign crowbar_o = active & cb_q;

  always_comb begin
    if (!active)        pg_code_o = PG_OPEN;
    else if (latched)   pg_code_o = code_q;
    else if (ss_busy_i) pg_code_o = PG_WEAK;
    else                pg_code_o = PG_OPEN;
  end
endmodule

// File: rtl/prot_fault_mgr_chk.sv
module prot_fault_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       supply_ok_i,
  input logic       ot_hi_i,
  input logic [1:0] pg_code_o,
  input logic       sw_en_o,
  input logic       crowbar_o
);
  logic act;
  assign act = en_i & supply_ok_i;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> (pg_code_o == 2'b00 && !sw_en_o && !crowbar_o)); // R8

  AST_LATCH_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    pg_code_o[1] |-> !sw_en_o); // R10

  AST_CROWBAR_OV_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    crowbar_o |-> (pg_code_o == 2'b10)); // R4

  AST_OT_BLOCKS_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    ot_hi_i |=> !sw_en_o); // R6

  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act) && $past(pg_code_o[1])) |-> (pg_code_o == $past(pg_code_o))); // R7
endmodule

bind prot_fault_mgr prot_fault_mgr_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .supply_ok_i(supply_ok_i),
  .ot_hi_i(ot_hi_i), .pg_code_o(pg_code_o), .sw_en_o(sw_en_o), .crowbar_o(crowbar_o)
);

// File: tb/prot_fault_mgr_tb.sv
module prot_fault_mgr_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic en_i, supply_ok_i, ss_busy_i, pulse_stb_i, us_tick_i;
  logic oc_flag_i, sc_flag_i, ov_hi_i, ov_lo_i, uv_flag_i, ot_hi_i, ot_warm_i;
  logic [1:0] pg_code_o;
  logic sw_en_o, crowbar_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prot_fault_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .supply_ok_i(supply_ok_i),
    .ss_busy_i(ss_busy_i), .pulse_stb_i(pulse_stb_i), .us_tick_i(us_tick_i),
    .oc_flag_i(oc_flag_i), .sc_flag_i(sc_flag_i), .ov_hi_i(ov_hi_i), .ov_lo_i(ov_lo_i),
    .uv_flag_i(uv_flag_i), .ot_hi_i(ot_hi_i), .ot_warm_i(ot_warm_i),
    .pg_code_o(pg_code_o), .sw_en_o(sw_en_o), .crowbar_o(crowbar_o)
  );

  // Input field order: en sok ss | stb tick oc sc | ovh ovl uv | oth otw
  localparam logic [11:0] OFF        = 12'b000_0000_000_00;
  localparam logic [11:0] ON         = 12'b110_0000_000_00;
  localparam logic [11:0] ON_TICK    = 12'b110_0100_000_00;
  localparam logic [11:0] ON_STB     = 12'b110_1000_000_00;
  localparam logic [11:0] ON_STB_OC  = 12'b110_1010_000_00;
  localparam logic [11:0] ON_TSTB_OC = 12'b110_1110_000_00;
  localparam logic [11:0] ON_STB_SC  = 12'b110_1001_000_00;

  // Row: {req[3:0], inputs[11:0], code[1:0], sw, crowbar}; expected after the edge.
  localparam int NV = 26;
  localparam logic [19:0] VEC [NV] = '{
    {4'd8,  12'b000_0000_000_00, 2'b00, 1'b0, 1'b0}, // R8 off
    {4'd8,  12'b100_0000_000_00, 2'b00, 1'b0, 1'b0}, // R8 supply not ready
    {4'd9,  12'b111_0000_000_00, 2'b01, 1'b1, 1'b0}, // R9 soft-start weak
    {4'd9,  12'b110_0000_000_00, 2'b00, 1'b1, 1'b0}, // R9 regulating open
    {4'd6,  12'b110_0000_000_11, 2'b00, 1'b0, 1'b0}, // R6 thermal trip
    {4'd6,  12'b110_0000_000_01, 2'b00, 1'b0, 1'b0}, // R6 still warm
    {4'd6,  12'b110_0000_000_00, 2'b00, 1'b1, 1'b0}, // R6 recovered
    {4'd4,  12'b110_0000_110_00, 2'b10, 1'b0, 1'b1}, // R4 overvoltage latch
    {4'd4,  12'b110_0000_010_00, 2'b10, 1'b0, 1'b1}, // R4 above release
    {4'd4,  12'b110_0000_000_00, 2'b10, 1'b0, 1'b0}, // R4 released
    {4'd4,  12'b110_0000_110_00, 2'b10, 1'b0, 1'b1}, // R4 re-trip
    {4'd7,  12'b110_0000_111_00, 2'b10, 1'b0, 1'b1}, // R7 first code kept
    {4'd8,  12'b010_0000_000_00, 2'b00, 1'b0, 1'b0}, // R8 enable low
    {4'd8,  12'b110_0000_000_00, 2'b00, 1'b1, 1'b0}, // R8 cleared
    {4'd5,  12'b110_0000_001_00, 2'b01, 1'b0, 1'b0}, // R5 undervoltage
    {4'd5,  12'b110_0000_000_00, 2'b01, 1'b0, 1'b0}, // R5 stays latched
    {4'd10, 12'b111_0000_000_00, 2'b01, 1'b0, 1'b0}, // R10 latched ignores ss
    {4'd8,  12'b100_0000_000_00, 2'b00, 1'b0, 1'b0}, // R8 supply lost
    {4'd8,  12'b110_0000_000_00, 2'b00, 1'b1, 1'b0}, // R8 cleared
    {4'd7,  12'b110_0000_101_00, 2'b10, 1'b0, 1'b1}, // R7 ov beats uv
    {4'd4,  12'b110_0000_000_00, 2'b10, 1'b0, 1'b0}, // R4 release
    {4'd8,  12'b000_0000_000_00, 2'b00, 1'b0, 1'b0}, // R8 off
    {4'd8,  12'b110_0000_000_00, 2'b00, 1'b1, 1'b0}, // R8 on
    {4'd3,  12'b110_1001_000_00, 2'b00, 1'b1, 1'b0}, // R3 first sc sample
    {4'd7,  12'b110_1001_101_00, 2'b11, 1'b0, 1'b0}, // R7 current beats ov, uv
    {4'd8,  12'b000_0000_000_00, 2'b00, 1'b0, 1'b0}  // R8 off
  };

  task automatic apply(input logic [11:0] v);
    {en_i, supply_ok_i, ss_busy_i, pulse_stb_i, us_tick_i, oc_flag_i, sc_flag_i,
     ov_hi_i, ov_lo_i, uv_flag_i, ot_hi_i, ot_warm_i} = v;
  endtask

  task automatic step(input logic [11:0] v);
    apply(v);
    @(posedge clk);
    #1;
  endtask

  task automatic check(input int req, input logic [1:0] code, input logic sw, input logic cb);
    checks++;
    if (pg_code_o !== code || sw_en_o !== sw || crowbar_o !== cb) begin
      errors++;
      $display("FAIL R%0d: code=%b sw=%b cb=%b expected code=%b sw=%b cb=%b",
               req, pg_code_o, sw_en_o, crowbar_o, code, sw, cb);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    apply(OFF);
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    check(8, 2'b00, 1'b0, 1'b0); // R8 reset state

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][15:4]);
      check(int'(VEC[i][19:16]), VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end

    // R1/R2: overcurrent duration timer
    step(OFF);
    step(ON);
    step(ON_STB_OC);
    for (int k = 1; k <= 20; k++) step((k % 5 == 0) ? ON_TSTB_OC : ON_TICK);
    check(1, 2'b00, 1'b1, 1'b0); // R1 exactly 20 ticks: no trip
    step(ON_STB);
    check(2, 2'b00, 1'b1, 1'b0); // R2 low sample resets
    step(ON_STB_OC);
    for (int k = 1; k <= 20; k++) step((k % 3 == 0) ? ON_TSTB_OC : ON_TICK);
    check(2, 2'b00, 1'b1, 1'b0); // R2 restarted from zero
    step(ON_TICK);
    check(1, 2'b11, 1'b0, 1'b0); // R1 trip on the 21st tick

    // R3: short-circuit window
    step(OFF);
    step(ON);
    step(ON_STB_SC);
    for (int k = 0; k < 10; k++) step(ON_TICK);
    step(ON_STB_SC);
    check(3, 2'b00, 1'b1, 1'b0); // R3 10 ticks apart: no trip
    for (int k = 0; k < 9; k++) step(ON_TICK);
    step(ON_STB_SC);
    check(3, 2'b11, 1'b0, 1'b0); // R3 9 ticks apart: trip

    step(OFF);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule